// File: doc/BRIEF.md
# Row-Major to Page-Column Pixel Transposer

This block reshapes a rectangle of a one-bit-per-pixel frame buffer, stored row after row, into the byte stream a page-organised monochrome panel consumes. In that stream each byte stands for one column of an eight-row band (a "page"), with the topmost row of the band in the least significant bit. The block fetches source bytes through a synchronous read port addressed by rectangle-relative row and byte index. It places each output byte on a valid/ready stream, together with the column and page it belongs to.

A start pulse carries the rectangle: column offset, width, top row and height. The block widens the rectangle vertically to whole pages and clips it to the panel height. It reads one 8×8 tile at a time (eight source rows of one source byte), then emits up to eight column bytes from that tile. The last byte of every page is flagged, so a downstream command generator can insert addressing commands between pages. Panel height and maximum width are parameters.

Top module: `pix_page_xpose`

## Requirements
- R1: After reset `out_valid`, `busy` and `rd_en` are low.
- R2: Source pixel j of rectangle row r is bit (j mod 8) of the byte read at `rd_row`=r, `rd_byte`=j/8, one cycle after `rd_en`. Bit k of an output byte for page p and column j holds rectangle row 8·p+k.
- R3: Bytes leave in order of column j=0..W-1 within a page, pages in increasing order. `out_col` = x+j (modulo 2^width of the port) and `out_page` = (snapped top)/8 + p.
- R4: The top row is rounded down to a multiple of 8. The bottom (top row + height) is rounded up to a multiple of 8 and then limited to DISP_H. Rectangle row 0 is the snapped top.
- R5: Rows of a page beyond the limited bottom read as 0 in the output byte and are not fetched.
- R6: `out_eop` is high with the last column byte of each page and low for all other bytes.
- R7: While `out_valid` is high and `out_ready` is low, `out_data`, `out_col`, `out_page` and `out_eop` hold their values.
- R8: `rd_en` is asserted only for rows inside the snapped, limited rectangle.
- R9: `start` is ignored while `busy` is high. It is also ignored for a rectangle with zero width or zero rows after snapping. While `busy` is low, neither `out_valid` nor `rd_en` is high.
- R10: A width above MAX_W is treated as MAX_W.
- R11: A run delivers exactly W × ceil(rows/8) bytes and then drops `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a rectangle (sampled when not busy) |
| in_x | input | CW | Column offset of the rectangle on the panel |
| in_w | input | WW | Rectangle width in pixels |
| in_y | input | HW | Rectangle top row |
| in_h | input | HW | Rectangle height in rows |
| busy | output | 1 | A run is in progress or a byte is still pending |
| rd_en | output | 1 | Source memory read enable |
| rd_row | output | RW | Rectangle-relative source row |
| rd_byte | output | BW | Source byte index within the row |
| rd_data | input | 8 | Source byte, one cycle after `rd_en` |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Column byte, LSB = top row of the page |
| out_eop | output | 1 | Last byte of the current page |
| out_col | output | CW | Panel column of the byte |
| out_page | output | PGW | Panel page of the byte |

## Verification
The bench targets a panel height that is not a multiple of eight, so the final page is partial. A design that skipped the masking would leak stale tile rows or out-of-range reads into the top bits. It also targets widths that are not multiples of eight and widths beyond the limit. Either would expose a tile that emits too many or too few columns, which shows up as a wrong byte count or misplaced end-of-page flags. Unaligned top rows and rectangles running off the panel test the snapping: an error there shifts every byte of a page. Random back-pressure and a start pulse issued mid-run catch an output that changes under a stall, or a run that restarts with the new rectangle.

// File: rtl/pix_page_xpose_pkg.sv
package pix_page_xpose_pkg;
  localparam int TILE = 8;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_DRAIN,
    S_EMIT
  } xp_state_e;
endpackage

// File: rtl/pix_page_xpose_geom.sv
// Rectangle geometry: vertical snapping to pages, clipping, width limit.
module pix_page_xpose_geom #(
  parameter int DISP_H = 64,
  parameter int MAX_W  = 128,
  parameter int HW     = 7,
  parameter int WW     = 8,
  parameter int PGW    = 5
) (
  input  logic [HW-1:0]  y,
  input  logic [HW-1:0]  h,
  input  logic [WW-1:0]  w,
  output logic [HW-1:0]  rows,
  output logic [PGW-1:0] pages,
  output logic [PGW-1:0] pg0,
  output logic [WW-1:0]  weff,
  output logic           go
);
  localparam int SW = HW + 2;

  logic [SW-1:0] top_s, bot_raw, bot, rows_s, pages_s;

  always_comb begin
    top_s   = SW'(y) & ~SW'(7);
    bot_raw = (SW'(y) + SW'(h) + SW'(7)) & ~SW'(7);
    bot     = (bot_raw > SW'(DISP_H)) ? SW'(DISP_H) : bot_raw;
    rows_s  = (bot > top_s) ? (bot - top_s) : '0;
    pages_s = (rows_s + SW'(7)) >> 3;
    rows    = HW'(rows_s);
    pages   = PGW'(pages_s);
    pg0     = PGW'(top_s >> 3);
    weff    = (w > WW'(MAX_W)) ? WW'(MAX_W) : w;
    go      = (rows_s != '0) && (weff != '0);
  end
endmodule

// File: rtl/pix_page_xpose_tile.sv
// 8x8 bit tile: captures eight source bytes, hands out one column at a time.
module pix_page_xpose_tile (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_en,
  input  logic [2:0] cap_idx,
  input  logic       cap_keep,
  input  logic [7:0] cap_data,
  input  logic [2:0] col_sel,
  output logic [7:0] col_byte
);
  logic [7:0] rowq [8];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) rowq[i] <= 8'h00;
    end else if (cap_en) begin
      rowq[cap_idx] <= cap_keep ? cap_data : 8'h00;
    end
  end

  for (genvar k = 0; k < 8; k++) begin : g_col
    assign col_byte[k] = rowq[k][col_sel];
  end
endmodule

// File: rtl/pix_page_xpose.sv
module pix_page_xpose #(
  parameter int DISP_H = 64,
  parameter int MAX_W  = 128,
  localparam int HW  = $clog2(DISP_H + 1),
  localparam int WW  = $clog2(MAX_W + 1),
  localparam int CW  = WW + 1,
  localparam int RW  = $clog2(DISP_H),
  localparam int NB  = (MAX_W + 7) / 8,
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1,
  localparam int PGW = HW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [CW-1:0]  in_x,
  input  logic [WW-1:0]  in_w,
  input  logic [HW-1:0]  in_y,
  input  logic [HW-1:0]  in_h,
  output logic           busy,
  output logic           rd_en,
  output logic [RW-1:0]  rd_row,
  output logic [BW-1:0]  rd_byte,
  input  logic [7:0]     rd_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data,
  output logic           out_eop,
  output logic [CW-1:0]  out_col,
  output logic [PGW-1:0] out_page
);
  import pix_page_xpose_pkg::*;

  xp_state_e st;

  logic [HW-1:0]  g_rows;
  logic [PGW-1:0] g_pages, g_pg0;
  logic [WW-1:0]  g_w;
  logic           g_go;

  logic [CW-1:0]  x_r;
  logic [WW-1:0]  w_r;
  logic [HW-1:0]  rows_r;
  logic [PGW-1:0] pages_r, pg0_r, pg_i;
  logic [BW-1:0]  by_i;
  logic [2:0]     k_i, c_i;

  logic           cap_en, cap_keep;
  logic [2:0]     cap_idx;
  logic [7:0]     col_byte;

  logic [HW-1:0]  row_base, rows_left;
  logic [WW:0]    col_base, cols_left;
  logic [3:0]     vrows, tcols;
  logic           last_col, last_byte, last_page, load;

  pix_page_xpose_geom #(
    .DISP_H(DISP_H), .MAX_W(MAX_W), .HW(HW), .WW(WW), .PGW(PGW)
  ) u_geom (
    .y(in_y), .h(in_h), .w(in_w),
    .rows(g_rows), .pages(g_pages), .pg0(g_pg0), .weff(g_w), .go(g_go)
  );

  pix_page_xpose_tile u_tile (
    .clk(clk), .rst(rst),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_keep(cap_keep), .cap_data(rd_data),
    .col_sel(c_i), .col_byte(col_byte)
  );

  always_comb begin
    row_base  = HW'({pg_i, 3'b000});
    rows_left = rows_r - row_base;
    vrows     = (rows_left >= HW'(8)) ? 4'd8 : 4'(rows_left);
    col_base  = (WW+1)'({by_i, 3'b000});
    cols_left = (WW+1)'(w_r) - col_base;
    tcols     = (cols_left >= (WW+1)'(8)) ? 4'd8 : 4'(cols_left);
    last_col  = ({1'b0, c_i} == (tcols - 4'd1));
    last_byte = ((col_base + (WW+1)'(8)) >= (WW+1)'(w_r));
    last_page = (pg_i == (pages_r - PGW'(1)));
    load      = (st == S_EMIT) && (!out_valid || out_ready);
    rd_en     = (st == S_FETCH) && ({1'b0, k_i} < vrows);
    rd_row    = RW'(row_base + HW'(k_i));
    rd_byte   = by_i;
    busy      = (st != S_IDLE) || out_valid;
  end

  // capture pipeline matching the one-cycle memory latency
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en   <= 1'b0;
      cap_keep <= 1'b0;
      cap_idx  <= 3'd0;
    end else begin
      cap_en   <= (st == S_FETCH);
      cap_keep <= rd_en;
      cap_idx  <= k_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      x_r       <= '0;
      w_r       <= '0;
      rows_r    <= '0;
      pages_r   <= '0;
      pg0_r     <= '0;
      pg_i      <= '0;
      by_i      <= '0;
      k_i       <= '0;
      c_i       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eop   <= 1'b0;
      out_col   <= '0;
      out_page  <= '0;
    end else begin
      if (out_valid && out_ready && !load) out_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start && g_go && !out_valid) begin
            x_r     <= in_x;
            w_r     <= g_w;
            rows_r  <= g_rows;
            pages_r <= g_pages;
            pg0_r   <= g_pg0;
            pg_i    <= '0;
            by_i    <= '0;
            k_i     <= '0;
            st      <= S_FETCH;
          end
        end
        S_FETCH: begin
          k_i <= k_i + 3'd1;
          if (k_i == 3'd7) st <= S_DRAIN;
        end
        S_DRAIN: begin
          c_i <= '0;
          st  <= S_EMIT;
        end
        S_EMIT: begin
          if (load) begin
            out_valid <= 1'b1;
            out_data  <= col_byte;
            out_eop   <= last_col && last_byte;
            out_col   <= x_r + CW'(col_base) + CW'(c_i);
            out_page  <= pg0_r + pg_i;
            if (last_col) begin
              c_i <= '0;
              k_i <= '0;
              if (last_byte) begin
                by_i <= '0;
                if (last_page) begin
                  st <= S_IDLE;
                end else begin
                  pg_i <= pg_i + PGW'(1);
                  st   <= S_FETCH;
                end
              end else begin
                by_i <= by_i + BW'(1);
                st   <= S_FETCH;
              end
            end else begin
              c_i <= c_i + 3'd1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pix_page_xpose_chk.sv
module pix_page_xpose_chk #(
  parameter int DISP_H = 64,
  parameter int RW  = 6,
  parameter int CW  = 9,
  parameter int PGW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           rd_en,
  input logic [RW-1:0]  rd_row,
  input logic           out_valid,
  input logic           out_ready,
  input logic [7:0]     out_data,
  input logic           out_eop,
  input logic [CW-1:0]  out_col,
  input logic [PGW-1:0] out_page
);
  localparam int REM = DISP_H % 8;

  logic          seq_on;
  logic [CW-1:0] seq_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_on  <= 1'b0;
      seq_col <= '0;
    end else if (out_valid && out_ready) begin
      seq_on  <= !out_eop;
      seq_col <= out_col + CW'(1);
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)
                                   && $stable(out_col) && $stable(out_page)));

  // R8
  rd_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rd_row) < DISP_H));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!out_valid && !rd_en));

  // R3
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seq_on) |-> (out_col == seq_col));

  if (REM != 0) begin : g_partial
    // R5
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (int'(out_page) == DISP_H / 8)) |-> ((out_data >> REM) == 8'h00));
  end
endmodule

bind pix_page_xpose pix_page_xpose_chk #(
  .DISP_H(DISP_H), .RW(RW), .CW(CW), .PGW(PGW)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .rd_en(rd_en), .rd_row(rd_row),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_eop(out_eop), .out_col(out_col), .out_page(out_page)
);

// File: tb/test_pix_page_xpose.sv
module test_pix_page_xpose;
  localparam int DH  = 36;
  localparam int MW  = 40;
  localparam int HW  = $clog2(DH + 1);
  localparam int WW  = $clog2(MW + 1);
  localparam int CW  = WW + 1;
  localparam int RW  = $clog2(DH);
  localparam int NB  = (MW + 7) / 8;
  localparam int BW  = (NB > 1) ? $clog2(NB) : 1;
  localparam int PGW = HW - 2;
  localparam int MAXB = MW * ((DH + 7) / 8);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CW-1:0] in_x = '0;
  logic [WW-1:0] in_w = '0;
  logic [HW-1:0] in_y = '0, in_h = '0;
  logic busy, rd_en, out_valid, out_eop;
  logic out_ready = 1'b0;
  logic [RW-1:0] rd_row;
  logic [BW-1:0] rd_byte;
  logic [7:0] rd_data = '0, out_data;
  logic [CW-1:0] out_col;
  logic [PGW-1:0] out_page;

  always #4 clk = ~clk;

  pix_page_xpose #(.DISP_H(DH), .MAX_W(MW)) i_pix_page_xpose (
    .clk(clk), .rst(rst), .start(start), .in_x(in_x), .in_w(in_w), .in_y(in_y),
    .in_h(in_h), .busy(busy), .rd_en(rd_en), .rd_row(rd_row), .rd_byte(rd_byte),
    .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_eop(out_eop), .out_col(out_col), .out_page(out_page)
  );

  logic [7:0] mem [DH][NB];
  always @(posedge clk)
    if (rd_en && int'(rd_row) < DH && int'(rd_byte) < NB) rd_data <= mem[rd_row][rd_byte];

  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic [7:0] e_d [MAXB];
  int e_c [MAXB];
  int e_p [MAXB];
  bit e_e [MAXB];
  int n_exp, b_rows;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic calc(int x, int w, int y, int h);
    int y0, bot, we, pages;
    y0 = y & ~7;
    bot = (y + h + 7) & ~7;
    if (bot > DH) bot = DH;
    b_rows = (bot > y0) ? bot - y0 : 0;
    we = (w > MW) ? MW : w;
    pages = (b_rows + 7) / 8;
    n_exp = 0;
    if (b_rows == 0 || we == 0) return;
    for (int p = 0; p < pages; p++)
      for (int j = 0; j < we; j++) begin
        logic [7:0] d;
        d = 8'h00;
        for (int k = 0; k < 8; k++)
          if (8 * p + k < b_rows) d[k] = mem[8 * p + k][j / 8][j % 8];
        e_d[n_exp] = d;
        e_c[n_exp] = (x + j) % (1 << CW);
        e_p[n_exp] = y0 / 8 + p;
        e_e[n_exp] = (j == we - 1);
        n_exp++;
      end
  endtask

  task automatic run_rect(int x, int w, int y, int h, bit poke);
    int got, cyc;
    bit stall, extra;
    logic [7:0] held;
    for (int r = 0; r < DH; r++)
      for (int b = 0; b < NB; b++) mem[r][b] = 8'($urandom);
    calc(x, w, y, h);
    @(negedge clk);
    in_x = CW'(x); in_w = WW'(w); in_y = HW'(y); in_h = HW'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; cyc = 0; stall = 0; held = '0;
    while (got < n_exp && cyc < 4000) begin
      // R9: a second start while running must not disturb the stream
      if (poke && cyc == 3) begin
        in_x = CW'(x + 5); in_w = WW'(3); in_y = '0; in_h = HW'(8); start = 1'b1;
      end else start = 1'b0;
      if (stall) chk(out_valid && out_data == held, "R7", int'(out_data), int'(held));
      if (rd_en && int'(rd_row) >= b_rows) chk(0, "R8", int'(rd_row), b_rows);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        chk(out_data == e_d[got], "R2 R4 R5", int'(out_data), int'(e_d[got]));
        chk(int'(out_col) == e_c[got] && int'(out_page) == e_p[got], "R3",
            int'(out_col) * 100 + int'(out_page), e_c[got] * 100 + e_p[got]);
        chk(out_eop == e_e[got], "R6", int'(out_eop), int'(e_e[got]));
        got++;
        stall = 0;
      end else begin
        stall = out_valid;
        held = out_data;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(got == n_exp, "R10 R11", got, n_exp);
    extra = 0;
    out_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (out_valid) extra = 1;
      @(negedge clk);
    end
    chk(!extra, "R11", int'(extra), 0);
    chk(!busy, "R9", int'(busy), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R11 watchdog act=%0d exp=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!out_valid && !busy && !rd_en, "R1", int'({out_valid, busy, rd_en}), 0);
    // directed corners
    run_rect(0, MW, 0, DH, 0);      // full panel, partial last page
    run_rect(3, 1, 8, 8, 0);        // single column
    run_rect(2, 13, 5, 6, 0);       // unaligned top, odd width
    run_rect(0, 50, 30, 20, 0);     // width over limit, bottom clipped (R10)
    run_rect(1, 17, 0, 16, 1);      // start pulse while busy (R9)
    // R9: empty rectangles are ignored
    run_rect(4, 0, 0, 8, 0);
    run_rect(4, 8, 40, 8, 0);
    for (int i = 0; i < 24; i++)
      run_rect(int'($urandom % 8), int'($urandom % (MW + 4)),
               int'($urandom % DH), int'($urandom % DH), bit'($urandom % 2));
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule